// File: doc/BRIEF.md
# Load/Store Port Handshake Checker

This block sits beside one load/store request port, between a load/store unit and a small cache or buffer. It drives nothing on that port. It follows the busy-driven handshake cycle by cycle and records the first broken rule in a sticky flag with a 3-bit code. A request is not fire-and-forget. Busy must rise with the request and hold until the request ends. Each way a request can end drops busy at a different point:

- An address exception ends it at once.
- Load data ends it in the same cycle.
- Store data ends it one cycle later.

The checker keeps a small phase register with five phases: idle, waiting for address accept, waiting for load data, waiting for store data, and the one-cycle store drain. It also keeps the captured address and one cycle of history for each pulse line. A request begins in the cycle its request line rises. The requester lowers that line for at least one cycle between requests. Reset is asynchronous and active low. The clear input wipes the flag.

Top module: `ldst_port_checker`

## Requirements
- R1: Load request and store request high in the same cycle sets error code 1.
- R2: Busy low when it must be high sets code 2. This covers three cases: a request starting from idle without busy; busy low while waiting for accept with no exception; and busy low while waiting for load data without the load pulse, or at any time while waiting for store data.
- R3: A request line rising while a request is still in progress (phase not idle) sets code 3.
- R4: Once address-valid has been seen for a request, a cycle with busy high and either address-valid low or a different address value sets code 4.
- R5: Any of address accept, address exception, load-data valid or store-data valid high in two consecutive cycles, or accept and exception together, sets code 5.
- R6: Out-of-place pulses set code 6. These are: accept or exception outside the waiting-for-accept phase; accept without address-valid; load-data valid outside the waiting-for-load phase; store-data valid outside the waiting-for-store phase.
- R7: Busy staying high where it must fall sets code 7. These cycles are: the exception cycle, the load-data cycle, and the cycle after the store-data pulse.
- R8: When several rules break in one cycle, the lowest code is stored. Once set, the flag and code hold unchanged, and later violations are ignored until cleared.
- R9: A clear pulse leaves flag and code at zero after the next clock edge. Clear wins over a violation in the same cycle.
- R10: After reset the flag is low and the code is 0.
- R11: Legal load, store and exception sequences never set the flag, for any number of wait cycles before the accept and before the data pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Clears the sticky error flag and code |
| ld_req_i | input | 1 | Observed load request |
| st_req_i | input | 1 | Observed store request |
| busy_i | input | 1 | Observed port busy |
| addr_vld_i | input | 1 | Observed address valid |
| addr_i | input | ADDR_W | Observed address value |
| addr_ack_i | input | 1 | Observed address accept pulse |
| addr_exc_i | input | 1 | Observed address exception pulse |
| ld_vld_i | input | 1 | Observed load-data valid pulse |
| st_vld_i | input | 1 | Observed store-data valid pulse |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | Code of the first broken rule |

## Verification
The bench sweeps the accept latency and the data latency across legal loads, stores and exceptions. This shows that the phase tracking waits correctly and does not fire on late pulses. Each rule is then broken alone from a known phase, so that each code can be told apart from its neighbours. Two mixed cases separate the priority order from the sticky hold: pulse plus orphan, and orphan plus busy tail. A clear after every fault checks that the flag returns to zero.

// File: rtl/ldst_chk_pkg.sv
package ldst_chk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_WAIT_ACK = 3'd1,
    PH_WAIT_LD  = 3'd2,
    PH_WAIT_ST  = 3'd3,
    PH_DRAIN    = 3'd4
  } phase_e;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] C_NONE    = 3'd0;
  localparam logic [CODE_W-1:0] C_DUAL    = 3'd1;
  localparam logic [CODE_W-1:0] C_BUSY    = 3'd2;
  localparam logic [CODE_W-1:0] C_OVERLAP = 3'd3;
  localparam logic [CODE_W-1:0] C_ADDR    = 3'd4;
  localparam logic [CODE_W-1:0] C_PULSE   = 3'd5;
  localparam logic [CODE_W-1:0] C_ORPHAN  = 3'd6;
  localparam logic [CODE_W-1:0] C_TAIL    = 3'd7;
endpackage

// File: rtl/ldst_chk_track.sv
module ldst_chk_track
  import ldst_chk_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic              busy_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_ack_i,
  input  logic              addr_exc_i,
  input  logic              ld_vld_i,
  input  logic              st_vld_i,
  output phase_e            phase_o,
  output logic              start_o,
  output logic              dual_o,
  output logic              addr_moved_o
);
  phase_e            phase_q, phase_d;
  logic              op_ld_q, op_ld_d;
  logic              req_q;
  logic              held_q, held_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;
  logic              active;

  assign dual_o  = ld_req_i & st_req_i;
  assign start_o = (ld_req_i | st_req_i) & ~req_q;
  assign active  = (phase_q != PH_IDLE) | (start_o & ~dual_o);
  assign addr_en = active & addr_vld_i & ~held_q;

  always_comb begin
    phase_d = phase_q;
    op_ld_d = op_ld_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_o && !dual_o) begin
          phase_d = PH_WAIT_ACK;
          op_ld_d = ld_req_i;
        end
      end
      PH_WAIT_ACK: begin
        if (addr_exc_i)      phase_d = PH_IDLE;
        else if (addr_ack_i) phase_d = op_ld_q ? PH_WAIT_LD : PH_WAIT_ST;
        else if (!busy_i)    phase_d = PH_IDLE;
      end
      PH_WAIT_LD: begin
        if (ld_vld_i || !busy_i) phase_d = PH_IDLE;
      end
      PH_WAIT_ST: begin
        if (st_vld_i)     phase_d = PH_DRAIN;
        else if (!busy_i) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    held_d = held_q;
    if (phase_d == PH_IDLE) held_d = 1'b0;
    else if (addr_en)       held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_ld_q <= 1'b0;
      req_q   <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      op_ld_q <= op_ld_d;
      req_q   <= ld_req_i | st_req_i;
      held_q  <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_i;
  end

  assign phase_o      = phase_q;
  assign addr_moved_o = held_q & (~addr_vld_i | (addr_i != addr_q));

  // R7
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT_ST && st_vld_i) |=> (phase_q == PH_DRAIN));
endmodule

// File: rtl/ldst_chk_rules.sv
module ldst_chk_rules
  import ldst_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic              start_i,
  input  logic              dual_i,
  input  logic              busy_i,
  input  logic              addr_vld_i,
  input  logic              addr_moved_i,
  input  logic              addr_ack_i,
  input  logic              addr_exc_i,
  input  logic              ld_vld_i,
  input  logic              st_vld_i,
  output logic [CODE_W-1:0] viol_o
);
  localparam int N_PULSE = 4;
  logic [N_PULSE-1:0] pulse_now, pulse_q;
  logic r_busy, r_overlap, r_addr, r_pulse, r_orphan, r_tail;

  assign pulse_now = {st_vld_i, ld_vld_i, addr_exc_i, addr_ack_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_now;
  end

  always_comb begin
    r_busy = (phase_i == PH_IDLE && start_i && !dual_i && !busy_i)
           | (phase_i == PH_WAIT_ACK && !busy_i && !addr_exc_i)
           | (phase_i == PH_WAIT_LD && !busy_i && !ld_vld_i)
           | (phase_i == PH_WAIT_ST && !busy_i);
    r_overlap = start_i && (phase_i != PH_IDLE);
    r_addr    = addr_moved_i && busy_i && (phase_i != PH_IDLE);
    r_pulse   = (|(pulse_now & pulse_q)) | (addr_ack_i & addr_exc_i);
    r_orphan  = ((addr_ack_i | addr_exc_i) && phase_i != PH_WAIT_ACK)
              | (addr_ack_i && !addr_vld_i && phase_i == PH_WAIT_ACK)
              | (ld_vld_i && phase_i != PH_WAIT_LD)
              | (st_vld_i && phase_i != PH_WAIT_ST);
    r_tail    = (phase_i == PH_WAIT_ACK && addr_exc_i && busy_i)
              | (phase_i == PH_WAIT_LD && ld_vld_i && busy_i)
              | (phase_i == PH_DRAIN && busy_i);
  end

  always_comb begin
    if (dual_i)         viol_o = C_DUAL;
    else if (r_busy)    viol_o = C_BUSY;
    else if (r_overlap) viol_o = C_OVERLAP;
    else if (r_addr)    viol_o = C_ADDR;
    else if (r_pulse)   viol_o = C_PULSE;
    else if (r_orphan)  viol_o = C_ORPHAN;
    else if (r_tail)    viol_o = C_TAIL;
    else                viol_o = C_NONE;
  end
endmodule

// File: rtl/ldst_chk_flag.sv
module ldst_chk_flag
  import ldst_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] viol_i,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o
);
  logic              err_q, err_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    err_d  = err_q;
    code_d = code_q;
    if (clear_i) begin
      err_d  = 1'b0;
      code_d = C_NONE;
    end else if (!err_q && viol_i != C_NONE) begin
      err_d  = 1'b1;
      code_d = viol_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= C_NONE;
    end else begin
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear_i) |=> (err_q && $stable(code_q)));
  // R9
  clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!err_q && code_q == C_NONE));
  // R8
  code_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (code_q != C_NONE));
endmodule

// File: rtl/ldst_port_checker.sv
module ldst_port_checker
  import ldst_chk_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic              busy_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_ack_i,
  input  logic              addr_exc_i,
  input  logic              ld_vld_i,
  input  logic              st_vld_i,
  output logic              err_o,
  output logic [2:0]        err_code_o
);
  phase_e            phase;
  logic              start, dual, addr_moved;
  logic [CODE_W-1:0] viol;

  ldst_chk_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .ld_req_i(ld_req_i), .st_req_i(st_req_i), .busy_i(busy_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i),
    .addr_ack_i(addr_ack_i), .addr_exc_i(addr_exc_i),
    .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i),
    .phase_o(phase), .start_o(start), .dual_o(dual),
    .addr_moved_o(addr_moved)
  );

  ldst_chk_rules u_rules (
    .clk(clk), .rst_n(rst_n),
    .phase_i(phase), .start_i(start), .dual_i(dual), .busy_i(busy_i),
    .addr_vld_i(addr_vld_i), .addr_moved_i(addr_moved),
    .addr_ack_i(addr_ack_i), .addr_exc_i(addr_exc_i),
    .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i),
    .viol_o(viol)
  );

  ldst_chk_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .viol_i(viol),
    .err_o(err_o), .code_o(err_code_o)
  );

  // R1
  dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && !clear_i && ld_req_i && st_req_i) |=> (err_o && err_code_o == 3'd1));
endmodule

// File: tb/ldst_port_checker_test.sv
module ldst_port_checker_test;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear_i = 1'b0;
  logic          ld_req = 1'b0, st_req = 1'b0, busy = 1'b0, avld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ack = 1'b0, exc = 1'b0, ldv = 1'b0, stv = 1'b0;
  logic          err_o;
  logic [2:0]    err_code_o;
  int            n_run = 0;
  int            n_fail = 0;

  always #4 clk = ~clk;

  ldst_port_checker #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .ld_req_i(ld_req), .st_req_i(st_req), .busy_i(busy),
    .addr_vld_i(avld), .addr_i(addr),
    .addr_ack_i(ack), .addr_exc_i(exc),
    .ld_vld_i(ldv), .st_vld_i(stv),
    .err_o(err_o), .err_code_o(err_code_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic all_low();
    ld_req = 0; st_req = 0; busy = 0; avld = 0;
    ack = 0; exc = 0; ldv = 0; stv = 0;
  endtask

  task automatic chk(input string tag, input logic exp_err, input logic [2:0] exp_code);
    n_run++;
    if (err_o !== exp_err || err_code_o !== exp_code) begin
      n_fail++;
      $display("FAIL %s: actual err=%0b code=%0d expected err=%0b code=%0d",
               tag, err_o, err_code_o, exp_err, exp_code);
    end
  endtask

  // back to idle, then clear; R9 checked after the clear
  task automatic recover();
    all_low();
    repeat (3) step();
    clear_i = 1; step(); clear_i = 0;
    chk("R9 clear", 1'b0, 3'd0);
  endtask

  task automatic begin_req(input logic is_ld, input logic [AW-1:0] a);
    ld_req = is_ld; st_req = ~is_ld; busy = 1; avld = 1; addr = a;
    step();
  endtask

  task automatic legal_load(input logic [AW-1:0] a, input int al, input int dl);
    begin_req(1'b1, a);
    repeat (al) step();
    ack = 1; step(); ack = 0;
    repeat (dl) step();
    ldv = 1; busy = 0; step();
    all_low(); step();
  endtask

  task automatic legal_store(input logic [AW-1:0] a, input int al, input int dl);
    begin_req(1'b0, a);
    repeat (al) step();
    ack = 1; step(); ack = 0;
    repeat (dl) step();
    stv = 1; step(); stv = 0;
    busy = 0; step();
    all_low(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R10 reset", 1'b0, 3'd0);

    // R11 latency sweep of legal sequences
    for (int al = 0; al < 4; al++) begin
      for (int dl = 0; dl < 4; dl++) begin
        legal_load(48'h1000 + AW'(al * 16 + dl), al, dl);
        chk("R11 load", 1'b0, 3'd0);
        legal_store(48'hA000_0000_0000 + AW'(al * 4 + dl), al, dl);
        chk("R11 store", 1'b0, 3'd0);
      end
      begin_req(al[0], AW'(al));
      repeat (al) step();
      exc = 1; busy = 0; step();
      all_low(); step();
      chk("R11 exception", 1'b0, 3'd0);
    end

    // R1 both requests
    ld_req = 1; st_req = 1; busy = 1; step();
    chk("R1 dual request", 1'b1, 3'd1);
    recover();

    // R2 request without busy
    ld_req = 1; busy = 0; avld = 1; step();
    chk("R2 start without busy", 1'b1, 3'd2);
    recover();

    // R2 busy dropped while waiting for accept
    begin_req(1'b0, 48'h55);
    busy = 0; step();
    chk("R2 early busy drop", 1'b1, 3'd2);
    recover();

    // R3 new request while in progress
    begin_req(1'b1, 48'h66);
    ack = 1; step(); ack = 0;
    ld_req = 0; step();
    st_req = 1; step();
    chk("R3 overlap", 1'b1, 3'd3);
    recover();

    // R4 address value changes
    begin_req(1'b1, 48'h77);
    addr = 48'h78; step();
    chk("R4 address moved", 1'b1, 3'd4);
    recover();

    // R4 address valid dropped
    begin_req(1'b0, 48'h79);
    avld = 0; step();
    chk("R4 address valid dropped", 1'b1, 3'd4);
    recover();

    // R5 accept held two cycles (also orphan; lower code wins)
    begin_req(1'b1, 48'h80);
    ack = 1; step(); step();
    chk("R5 accept twice", 1'b1, 3'd5);
    recover();

    // R5 accept and exception together
    begin_req(1'b1, 48'h81);
    ack = 1; exc = 1; step();
    chk("R5 accept with exception", 1'b1, 3'd5);
    recover();

    // R6 accept with nothing pending
    ack = 1; step();
    chk("R6 accept in idle", 1'b1, 3'd6);
    recover();

    // R6 load pulse during a store
    begin_req(1'b0, 48'h82);
    ack = 1; step(); ack = 0;
    ldv = 1; step();
    chk("R6 load pulse in store", 1'b1, 3'd6);
    recover();

    // R7 exception with busy high
    begin_req(1'b1, 48'h83);
    exc = 1; step();
    chk("R7 exception busy", 1'b1, 3'd7);
    recover();

    // R7 load data with busy high
    begin_req(1'b1, 48'h84);
    ack = 1; step(); ack = 0;
    ldv = 1; step();
    chk("R7 load busy", 1'b1, 3'd7);
    recover();

    // R7 busy still high after store pulse
    begin_req(1'b0, 48'h85);
    ack = 1; step(); ack = 0;
    stv = 1; step(); stv = 0;
    chk("R7 store pulse legal so far", 1'b0, 3'd0);
    step();
    chk("R7 store tail busy", 1'b1, 3'd7);
    recover();

    // R8 priority: orphan store pulse beats load busy tail
    begin_req(1'b1, 48'h86);
    ack = 1; step(); ack = 0;
    ldv = 1; stv = 1; step();
    chk("R8 priority 6 over 7", 1'b1, 3'd6);
    recover();

    // R8 sticky: later violations do not overwrite
    ld_req = 1; st_req = 1; busy = 1; step();
    all_low(); step();
    ack = 1; step(); ack = 0; step();
    chk("R8 sticky code", 1'b1, 3'd1);
    recover();

    // R9 clear wins over same-cycle violation
    ack = 1; clear_i = 1; step();
    clear_i = 0; ack = 0;
    chk("R9 clear over violation", 1'b0, 3'd0);
    step();
    chk("R9 stays clear", 1'b0, 3'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule